// File: doc/BRIEF.md
# Endpoint Test Command Engine

This block is the test function behind a bus endpoint's first address window. Host software programs a small register file (a scratch word, a source and a destination buffer address, a byte count, an interrupt kind and an interrupt vector) and then writes a command word. The engine picks one data operation from the command, checks the buffer addresses it needs, and moves whole 32-bit words over a simple request/acknowledge memory master port. While it moves data it folds every word into an XOR checksum.

When the operation ends, the engine reports the outcome in a status register. The status register has a separate success bit and a separate fail bit for each of read, write and copy, plus two bits that flag a bad source or a bad destination address. It then issues a completion interrupt as a one-cycle request that carries the kind and vector taken from the programmed registers. A command that holds only interrupt bits skips the data phase and raises that interrupt directly. A legacy interrupt must use vector 0, an MSI vector must lie in 1 to 32, and an MSI-X vector must lie in 1 to 2048. If the vector is outside the range for its kind, no request is issued.

Top module: `ep_test_engine`

## Requirements
- R1: Register offsets (word index on `reg_addr`) are 0 scratch, 1 command, 2 status, 3 source address, 4 destination address, 5 byte count, 6 checksum, 7 interrupt kind, 8 interrupt vector. The scratch register reads back the last value written to it, and after reset every register reads 0.
- R2: A write to offset 1 while `busy` is low stores bits 5:0 as the command, clears the status register and raises `busy` on the next cycle. A write to offset 1 while `busy` is high is ignored: it changes neither the running operation nor the command readback.
- R3: Command bit 3 (read) fetches count/4 words from source + 4*i, in ascending order. It sets status bit 0 when the XOR of those words equals the checksum register and sets status bit 1 otherwise. A read leaves the checksum register unchanged.
- R4: Command bit 4 (write) stores the word scratch + i at destination + 4*i, sets status bit 2 and loads the checksum register with the XOR of the words written.
- R5: Command bit 5 (copy) moves each word from source + 4*i to destination + 4*i, one word at a time in ascending order. It sets status bit 4 and loads the checksum register with the XOR of the moved words.
- R6: An address is invalid when it is zero or when its low two bits are not zero. A bad source (read or copy) sets status bit 7, and a bad destination (write or copy) sets status bit 8. In either case the operation's fail bit (1, 3 or 5) is set and no memory access is made.
- R7: The byte count is rounded down to whole words. A count below 4 makes no memory access and sets the operation's success bit.
- R8: Every command with a data bit or an interrupt bit ends with one interrupt request. `irq_req` is high for exactly one cycle, `irq_kind` equals the kind register (0 legacy, 1 MSI, 2 MSI-X) and `irq_vec` equals the vector register. Status bit 6 becomes set, and the success or fail bit is already set before the request.
- R9: When the vector is illegal for the kind (legacy needs 0, MSI needs 1..32, MSI-X needs 1..2048), or the kind is 3, no request is issued and status bit 6 stays clear.
- R10: A command with any of bits 2:0 set and no data bit makes no memory access and raises the interrupt described in R8 and R9. A command of 0 makes no access, raises nothing and leaves the status at 0.
- R11: When more than one data bit is set, only one operation runs, with read taking precedence over write and write over copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle completion of the current request |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_kind | output | 2 | Interrupt kind: 0 legacy, 1 MSI, 2 MSI-X |
| irq_vec | output | 12 | Interrupt vector |

## Verification
The bench targets the edges of the vector ranges: MSI 32 against 33, MSI-X 2048, legacy with vector 1, and kind 3. A design that is off by one in these checks would raise a request where none is allowed, or drop a legal one. It also tests byte counts of 3 and 6, a zero source, a misaligned destination and a copy with both addresses bad. A wrong rounding or a missing address check shows up as stray memory traffic or wrong fail bits. A read with a deliberately wrong checksum, a command that combines several data bits, and a second command written while the engine is busy complete the directed set. A design that compares against the wrong value, runs the wrong operation or accepts the second command would leave the status, the checksum or the access count off the predicted values. Random commands over overlapping buffers and slow memory acknowledges then check memory contents word by word.

// File: rtl/ep_test_engine.sv
module ep_test_engine #(
  parameter int VEC_W    = 12,
  parameter int MSI_MAX  = 32,
  parameter int MSIX_MAX = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ack,
  output logic             irq_req,
  output logic [1:0]       irq_kind,
  output logic [VEC_W-1:0] irq_vec
);
  localparam logic [1:0] OP_NONE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2, OP_CP = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_RD, S_WR, S_DONE, S_IRQ} state_t;
  state_t state;

  logic [31:0] magic_q, src_q, dst_q, csum_q, inum_q, acc_q, data_q;
  logic [29:0] size_q, idx_q;
  logic [5:0]  cmd_q;
  logic [8:0]  status_q;
  logic [1:0]  itype_q, op;
  logic        bad_q, src_bad, dst_bad, need_src, need_dst, last, vec_ok, ok;

  assign op = cmd_q[3] ? OP_RD : cmd_q[4] ? OP_WR : cmd_q[5] ? OP_CP : OP_NONE;
  assign need_src = (op == OP_RD) || (op == OP_CP);
  assign need_dst = (op == OP_WR) || (op == OP_CP);
  assign src_bad  = (src_q == 32'd0) || (src_q[1:0] != 2'd0);
  assign dst_bad  = (dst_q == 32'd0) || (dst_q[1:0] != 2'd0);
  assign last     = (idx_q + 30'd1) == size_q;
  assign ok       = !bad_q && (op != OP_RD || size_q == 30'd0 || acc_q == csum_q);

  always_comb begin
    case (itype_q)
      2'd0:    vec_ok = inum_q == 32'd0;
      2'd1:    vec_ok = inum_q >= 32'd1 && inum_q <= 32'(MSI_MAX);
      2'd2:    vec_ok = inum_q >= 32'd1 && inum_q <= 32'(MSIX_MAX);
      default: vec_ok = 1'b0;
    endcase
  end

  assign busy      = state != S_IDLE;
  assign mem_req   = (state == S_RD) || (state == S_WR);
  assign mem_we    = state == S_WR;
  assign mem_addr  = ((state == S_RD) ? src_q : dst_q) + {idx_q, 2'b00};
  assign mem_wdata = (op == OP_CP) ? data_q : magic_q + {2'b00, idx_q};
  assign irq_req   = (state == S_IRQ) && vec_ok;
  assign irq_kind  = itype_q;
  assign irq_vec   = inum_q[VEC_W-1:0];

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = magic_q;
      4'd1:    reg_rdata = {26'd0, cmd_q};
      4'd2:    reg_rdata = {23'd0, status_q};
      4'd3:    reg_rdata = src_q;
      4'd4:    reg_rdata = dst_q;
      4'd5:    reg_rdata = {size_q, 2'b00};
      4'd6:    reg_rdata = csum_q;
      4'd7:    reg_rdata = {30'd0, itype_q};
      4'd8:    reg_rdata = inum_q;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      magic_q <= '0; src_q <= '0; dst_q <= '0; csum_q <= '0; inum_q <= '0;
      acc_q <= '0; data_q <= '0; size_q <= '0; idx_q <= '0; cmd_q <= '0;
      status_q <= '0; itype_q <= '0; bad_q <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          4'd0: magic_q <= reg_wdata;
          4'd1: if (state == S_IDLE) begin
                  cmd_q    <= reg_wdata[5:0];
                  status_q <= '0;
                  state    <= S_CHECK;
                end
          4'd3: src_q   <= reg_wdata;
          4'd4: dst_q   <= reg_wdata;
          4'd5: size_q  <= reg_wdata[31:2];
          4'd6: csum_q  <= reg_wdata;
          4'd7: itype_q <= reg_wdata[1:0];
          4'd8: inum_q  <= reg_wdata;
          default: ;
        endcase
      end
      case (state)
        S_CHECK: begin
          idx_q <= '0;
          acc_q <= '0;
          bad_q <= 1'b0;
          if (op == OP_NONE)
            state <= (cmd_q[2:0] != 3'd0) ? S_IRQ : S_IDLE;
          else if ((need_src && src_bad) || (need_dst && dst_bad)) begin
            status_q[7] <= need_src && src_bad;
            status_q[8] <= need_dst && dst_bad;
            bad_q <= 1'b1;
            state <= S_DONE;
          end else if (size_q == 30'd0)
            state <= S_DONE;
          else
            state <= (op == OP_WR) ? S_WR : S_RD;
        end
        S_RD: if (mem_ack) begin
          acc_q  <= acc_q ^ mem_rdata;
          data_q <= mem_rdata;
          if (op == OP_CP) state <= S_WR;
          else begin
            idx_q <= idx_q + 30'd1;
            if (last) state <= S_DONE;
          end
        end
        S_WR: if (mem_ack) begin
          if (op == OP_WR) acc_q <= acc_q ^ mem_wdata;
          idx_q <= idx_q + 30'd1;
          if (last) state <= S_DONE;
          else if (op == OP_CP) state <= S_RD;
        end
        S_DONE: begin
          case (op)
            OP_RD:   status_q[ok ? 0 : 1] <= 1'b1;
            OP_WR:   status_q[ok ? 2 : 3] <= 1'b1;
            default: status_q[ok ? 4 : 5] <= 1'b1;
          endcase
          if (!bad_q && op != OP_RD) csum_q <= acc_q;
          state <= S_IRQ;
        end
        S_IRQ: begin
          if (vec_ok) status_q[6] <= 1'b1;
          state <= S_IDLE;
        end
        default: ;
      endcase
    end
  end

  p_cmd_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'd1 && !busy) |=> (status_q == 9'd0 && busy));
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  p_aligned_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'd0));
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);
  p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> status_q[6]);
  p_report_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && cmd_q[5:3] != 3'd0) |-> (status_q[5:0] != 6'd0));
  p_kind_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_kind != 2'd3));
endmodule

// File: tb/ep_test_engine_tb_top.sv
module ep_test_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic busy, mem_req, mem_we, mem_ack, irq_req;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0] irq_kind;
  logic [11:0] irq_vec;

  always #4 clk = ~clk;

  ep_test_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .irq_req(irq_req), .irq_kind(irq_kind), .irq_vec(irq_vec));

  logic [31:0] mem [0:255];
  logic [31:0] ref_mem [0:255];
  int nchk = 0, nerr = 0, acc_cnt = 0, irq_cnt = 0;
  logic [1:0] last_kind;
  logic [11:0] last_vec;
  logic [31:0] magic_v;
  int dly = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_rdata <= '0; dly <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (dly == 0) begin
          mem_ack <= 1'b1;
          if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
          else mem_rdata <= mem[mem_addr[9:2]];
          acc_cnt <= acc_cnt + 1;
          dly <= int'($urandom % 3);
        end else dly <= dly - 1;
      end
    end
    if (irq_req) begin
      irq_cnt <= irq_cnt + 1; last_kind <= irq_kind; last_vec <= irq_vec;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
  endtask

  function automatic bit vec_legal(input logic [1:0] t, input logic [31:0] n);
    case (t)
      2'd0: return n == 0;
      2'd1: return n >= 1 && n <= 32;
      2'd2: return n >= 1 && n <= 2048;
      default: return 0;
    endcase
  endfunction

  function automatic bit addr_bad(input logic [31:0] a);
    return a == 0 || a[1:0] != 0;
  endfunction

  task automatic run_op(input logic [5:0] cmd, input logic [31:0] src, input logic [31:0] dst,
                        input logic [31:0] size, input bit good_csum, input logic [31:0] bad_csum,
                        input logic [1:0] it, input logic [31:0] inum, input bit poke);
    int op, nw, a0, i0, exp_acc, mis;
    logic [31:0] st, v, exp_st, exp_cs, acc, csum_in;
    bit sb, db, bad, ok, fire;
    string tg;
    op = cmd[3] ? 1 : cmd[4] ? 2 : cmd[5] ? 3 : 0;
    nw = int'(size >> 2);
    wr(3, src); wr(4, dst); wr(5, size); wr(7, {30'd0, it}); wr(8, inum);
    acc = 0;
    for (int i = 0; i < nw; i++) acc ^= ref_mem[((src >> 2) + i) & 255];
    csum_in = good_csum ? acc : bad_csum;
    wr(6, csum_in);
    sb = (op == 1 || op == 3) && addr_bad(src);
    db = (op == 2 || op == 3) && addr_bad(dst);
    bad = sb || db;
    exp_st = 0; exp_cs = csum_in; exp_acc = 0;
    tg = op == 1 ? "R3" : op == 2 ? "R4" : op == 3 ? "R5" : "R10";
    if (cmd[3] && (cmd[4] || cmd[5])) tg = "R11";
    if (bad) tg = "R6"; else if (op != 0 && nw == 0) tg = "R7";
    if (op != 0) begin
      ok = 1; acc = 0;
      if (!bad) begin
        for (int i = 0; i < nw; i++) begin
          if (op == 1) acc ^= ref_mem[((src >> 2) + i) & 255];
          else if (op == 2) begin
            v = magic_v + i; ref_mem[((dst >> 2) + i) & 255] = v; acc ^= v;
          end else begin
            v = ref_mem[((src >> 2) + i) & 255]; ref_mem[((dst >> 2) + i) & 255] = v; acc ^= v;
          end
        end
        exp_acc = (op == 3) ? 2 * nw : nw;
        if (op == 1) ok = (nw == 0) || acc == csum_in; else exp_cs = acc;
      end else ok = 0;
      exp_st[(op - 1) * 2 + (ok ? 0 : 1)] = 1'b1;
      exp_st[7] = sb; exp_st[8] = db;
    end
    fire = (op != 0 || cmd[2:0] != 0) && vec_legal(it, inum);
    if (fire) exp_st[6] = 1'b1;
    a0 = acc_cnt; i0 = irq_cnt;
    wr(1, {26'd0, cmd});
    if (poke) wr(1, 32'h0000_0001);
    wait_idle();
    chk({"R2 idle ", tg}, {31'd0, busy}, 0);
    rd(2, st); chk({tg, " status"}, st, exp_st);
    rd(6, st); chk({tg, " checksum"}, st, exp_cs);
    rd(1, st); chk("R2 command readback", st, {26'd0, cmd});
    chk({tg, " access count"}, acc_cnt - a0, exp_acc);
    chk(fire ? "R8 irq count" : "R9 irq count", irq_cnt - i0, fire ? 1 : 0);
    if (fire) begin
      chk("R8 irq kind", {30'd0, last_kind}, {30'd0, it});
      chk("R8 irq vector", {20'd0, last_vec}, {20'd0, inum[11:0]});
    end
    if ((op == 2 || op == 3) && !bad) begin
      mis = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) mis++;
      chk({tg, " memory image"}, mis, 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 256; i++) begin
      mem[i] = $urandom; ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2, d); chk("R1 reset status", d, 0);
    rd(0, d); chk("R1 reset scratch", d, 0);
    chk("R1 reset busy", {31'd0, busy}, 0);
    magic_v = 32'hA5C3_0F12;
    wr(0, magic_v); rd(0, d); chk("R1 scratch readback", d, magic_v);

    run_op(6'h08, 32'h40, 32'h0, 32'd32, 1, 0, 2'd1, 32'd5, 0);
    run_op(6'h08, 32'h40, 32'h0, 32'd32, 0, 32'h1234_5678, 2'd0, 32'd0, 0);
    run_op(6'h10, 32'h0, 32'h200, 32'd20, 0, 0, 2'd2, 32'd2048, 0);
    run_op(6'h20, 32'h100, 32'h300, 32'd64, 0, 0, 2'd1, 32'd32, 0);
    run_op(6'h20, 32'h100, 32'h104, 32'd40, 0, 0, 2'd1, 32'd1, 0);
    run_op(6'h10, 32'h0, 32'h200, 32'd3, 0, 32'hdead_beef, 2'd1, 32'd7, 0);
    run_op(6'h08, 32'h80, 32'h0, 32'd6, 1, 0, 2'd1, 32'd7, 0);
    run_op(6'h08, 32'h0, 32'h0, 32'd16, 1, 0, 2'd1, 32'd3, 0);
    run_op(6'h10, 32'h0, 32'h202, 32'd16, 0, 0, 2'd1, 32'd3, 0);
    run_op(6'h20, 32'h0, 32'h2, 32'd16, 0, 0, 2'd0, 32'd0, 0);
    run_op(6'h02, 32'h0, 32'h0, 32'd16, 0, 0, 2'd1, 32'd32, 0);
    run_op(6'h02, 32'h0, 32'h0, 32'd16, 0, 0, 2'd1, 32'd33, 0);
    run_op(6'h04, 32'h0, 32'h0, 32'd16, 0, 0, 2'd2, 32'd2049, 0);
    run_op(6'h01, 32'h0, 32'h0, 32'd16, 0, 0, 2'd0, 32'd1, 0);
    run_op(6'h01, 32'h0, 32'h0, 32'd16, 0, 0, 2'd3, 32'd0, 0);
    run_op(6'h00, 32'h40, 32'h80, 32'd16, 0, 0, 2'd1, 32'd4, 0);
    run_op(6'h38, 32'h40, 32'h280, 32'd24, 1, 0, 2'd1, 32'd4, 0);
    run_op(6'h30, 32'h40, 32'h280, 32'd24, 0, 0, 2'd1, 32'd4, 0);
    run_op(6'h20, 32'h20, 32'h340, 32'd64, 0, 0, 2'd2, 32'd9, 1);

    for (int n = 0; n < 60; n++) begin
      logic [5:0] c;
      logic [31:0] s, t, z, num;
      logic [1:0] k;
      int r;
      r = int'($urandom % 4);
      c = r == 0 ? 6'h08 : r == 1 ? 6'h10 : r == 2 ? 6'h20 : 6'(1 << ($urandom % 3));
      s = {22'd0, 8'(1 + $urandom % 200), 2'b00};
      t = {22'd0, 8'(1 + $urandom % 200), 2'b00};
      if ($urandom % 8 == 0) s = ($urandom % 2) ? 32'd0 : s + 32'd1;
      if ($urandom % 8 == 0) t = ($urandom % 2) ? 32'd0 : t + 32'd2;
      z = $urandom % 68;
      k = 2'($urandom % 4);
      num = ($urandom % 4 == 0) ? $urandom % 2100 : (k == 0 ? 0 : k == 1 ? 1 + $urandom % 32 : 1 + $urandom % 2048);
      magic_v = $urandom; wr(0, magic_v);
      run_op(c, s, t, z, $urandom % 2 == 1, $urandom, k, num, 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule